// File: doc/BRIEF.md
# Sigma-Delta ADC Register Access Engine

This block is the serial master that sits between a host and a sigma-delta converter which speaks a command-byte register protocol. The host hands it one request at a time: read a register, write a register, send the interface reset pattern, or wait for the converter to signal ready. For register accesses the engine builds the command byte, then shifts out the value or shifts in the reply. The value is 1 to 3 bytes long, most significant byte first. The serial clock idles high, data changes on falling edges and is sampled on rising edges.

The converter's data-out pin also acts as its ready flag, so the engine can keep chip select low after a transfer. With chip select held low, a later wait-for-ready request watches the synchronised data-out line for a low level. A typical sequence writes the mode register with the hold flag set, waits for ready, and then reads the data register. A timeout ends a wait that never sees ready. When the identity register (address 4) is read, the low nibble of the reply is compared with an expected code and a warning level is raised on a mismatch.

Top module: `sdadc_reg_engine`

## Requirements
- R1: The command byte is sent first, MSB first: bit 7 is 0, bit 6 is 1 for a read and 0 for a write, bits 5:3 carry `req_addr`, bit 2 carries `req_cread`, and bits 1:0 are 0.
- R2: A write (`req_op`=1) sends the command byte and then the low `req_len` bytes of `req_wdata`, most significant first. The serial clock is high whenever chip select is high, which gives exactly 8*(len+1) rising edges.
- R3: A read or write with `req_len`=0 is acknowledged and completes in the same cycle with `rsp_err`=1, and produces no serial clock edge and no change of chip select.
- R4: A read (`req_op`=0) clocks in `req_len` bytes after the command byte. On `rsp_done` it presents them right-aligned in `rsp_rdata`, first byte most significant, with unused upper bits zero. MOSI is 0 during the data bytes.
- R5: An interface reset (`req_op`=2) sends 48 consecutive 1 bits with chip select low. It then releases chip select and signals `rsp_done` no sooner than RESET_WAIT clock cycles later.
- R6: After a read or write, chip select stays low if `req_hold` was set with the request, and returns high otherwise.
- R7: A ready wait (`req_op`=3) drives chip select low. It completes without error once MISO has been seen low (through a two-flop synchroniser) and no earlier. After READY_TIMEOUT cycles without ready it completes with `rsp_err`=1 and releases chip select.
- R8: After a read of address 4, `id_warn` is 1 exactly when `rsp_rdata[3:0]` differs from `id_expect`. The read itself completes with no error.
- R9: `req_ack` is a one-cycle pulse given only when the engine is idle. A request held valid during a transfer is not acknowledged again until that transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ack | output | 1 | Request accepted (one-cycle pulse) |
| req_op | input | 2 | 0 read, 1 write, 2 interface reset, 3 wait for ready |
| req_addr | input | 3 | Register address |
| req_len | input | 2 | Value length in bytes (1 to 3) |
| req_wdata | input | 24 | Write value, right-aligned |
| req_hold | input | 1 | Keep chip select low after the request |
| req_cread | input | 1 | Continuous-read bit of the command byte |
| id_expect | input | 4 | Expected identity code |
| rsp_done | output | 1 | Request complete (one-cycle pulse) |
| rsp_err | output | 1 | Bad length or ready timeout |
| rsp_rdata | output | 24 | Read value, right-aligned |
| id_warn | output | 1 | Identity mismatch on last identity read |
| sclk | output | 1 | Serial clock, idle high |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to converter |
| miso | input | 1 | Serial data and ready flag from converter |

## Verification
A table drives writes and reads of one, two and three bytes to different addresses. Comparing the captured MOSI bits shows whether the command byte fields, the byte count and the byte order are right. Comparing the right-aligned read results catches a wrong shift amount or a missing mask. Directed cases cover the rest: zero length, the 48-bit reset pattern and its wait, the hold, wait and read sequence, a ready timeout, matching and mismatching identity codes, and a request kept valid across a busy transfer.

// File: rtl/sdadc_reg_engine.sv
module sdadc_reg_engine #(
  parameter int CLK_DIV       = 4,
  parameter int RESET_WAIT    = 50000,
  parameter int READY_TIMEOUT = 200000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ack,
  input  logic [1:0]  req_op,
  input  logic [2:0]  req_addr,
  input  logic [1:0]  req_len,
  input  logic [23:0] req_wdata,
  input  logic        req_hold,
  input  logic        req_cread,
  input  logic [3:0]  id_expect,
  output logic        rsp_done,
  output logic        rsp_err,
  output logic [23:0] rsp_rdata,
  output logic        id_warn,
  output logic        sclk,
  output logic        cs_n,
  output logic        mosi,
  input  logic        miso
);
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_RST = 2'd2;
  localparam logic [2:0] ID_ADDR = 3'd4;
  localparam int DW = $clog2(CLK_DIV + 1);
  localparam int WMAX = (RESET_WAIT > READY_TIMEOUT) ? RESET_WAIT : READY_TIMEOUT;
  localparam int WW = $clog2(WMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP, S_WAIT} state_t;
  state_t state;

  logic [1:0]    op_q, len_q;
  logic [2:0]    addr_q;
  logic          hold_q, ph;
  logic [47:0]   tx;
  logic [23:0]   rx, rx_al, wd_al;
  logic [5:0]    nbits, bits;
  logic [DW-1:0] dcnt;
  logic [WW-1:0] wcnt;
  logic          m1, m2;
  logic [7:0]    cmd;

  assign cmd   = {1'b0, req_op == OP_RD, req_addr, req_cread, 2'b00};
  assign wd_al = (req_op == OP_WR) ? (req_wdata << {~req_len, 3'b000}) : 24'h0;

  always_comb begin
    case (len_q)
      2'd1:    rx_al = {16'h0, rx[7:0]};
      2'd2:    rx_al = {8'h0, rx[15:0]};
      default: rx_al = rx;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= 1'b1;
      m2 <= 1'b1;
    end else begin
      m1 <= miso;
      m2 <= m1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      req_ack <= 1'b0; rsp_done <= 1'b0; rsp_err <= 1'b0;
      rsp_rdata <= '0; id_warn <= 1'b0;
      sclk <= 1'b1; cs_n <= 1'b1; mosi <= 1'b1;
      op_q <= '0; len_q <= '0; addr_q <= '0; hold_q <= 1'b0; ph <= 1'b1;
      tx <= '0; rx <= '0; nbits <= '0; bits <= '0; dcnt <= '0; wcnt <= '0;
    end else begin
      req_ack  <= 1'b0;
      rsp_done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          req_ack <= 1'b1;
          op_q <= req_op; len_q <= req_len; addr_q <= req_addr; hold_q <= req_hold;
          rsp_err <= 1'b0;
          dcnt <= '0; wcnt <= '0; bits <= '0; ph <= 1'b1;
          case (req_op)
            OP_RD, OP_WR:
              if (req_len == 2'd0) begin
                rsp_done <= 1'b1;
                rsp_err  <= 1'b1;
              end else begin
                tx    <= {cmd, wd_al, 16'h0};
                nbits <= {1'b0, req_len, 3'b000} + 6'd8;
                cs_n  <= 1'b0;
                state <= S_SHIFT;
              end
            OP_RST: begin
              tx    <= '1;
              nbits <= 6'd48;
              cs_n  <= 1'b0;
              state <= S_SHIFT;
            end
            default: begin
              cs_n  <= 1'b0;
              state <= S_WAIT;
            end
          endcase
        end
        S_SHIFT:
          if (dcnt == DW'(CLK_DIV - 1)) begin
            dcnt <= '0;
            if (!ph) begin
              sclk <= 1'b1;
              rx   <= {rx[22:0], miso};
              tx   <= {tx[46:0], 1'b1};
              bits <= bits + 6'd1;
              ph   <= 1'b1;
            end else if (bits == nbits) begin
              mosi <= 1'b1;
              if (op_q == OP_RST) begin
                cs_n  <= 1'b1;
                state <= S_GAP;
              end else begin
                cs_n     <= ~hold_q;
                rsp_done <= 1'b1;
                state    <= S_IDLE;
                if (op_q == OP_RD) begin
                  rsp_rdata <= rx_al;
                  if (addr_q == ID_ADDR) id_warn <= (rx[3:0] != id_expect);
                end
              end
            end else begin
              sclk <= 1'b0;
              mosi <= tx[47];
              ph   <= 1'b0;
            end
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        S_GAP:
          if (wcnt == WW'(RESET_WAIT - 1)) begin
            rsp_done <= 1'b1;
            wcnt     <= '0;
            state    <= S_IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        default:
          if (wcnt >= WW'(2) && !m2) begin
            rsp_done <= 1'b1;
            cs_n     <= ~hold_q;
            state    <= S_IDLE;
          end else if (wcnt == WW'(READY_TIMEOUT - 1)) begin
            rsp_done <= 1'b1;
            rsp_err  <= 1'b1;
            cs_n     <= 1'b1;
            state    <= S_IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
      endcase
    end
  end

  p_cmd_msb_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SHIFT && op_q != OP_RST && bits == 6'd0 && !ph) |-> !mosi);

  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  p_badlen_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && req_valid && !req_op[1] && req_len == 2'd0)
      |=> (rsp_done && rsp_err && $stable(cs_n) && $stable(sclk)));

  p_reset_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SHIFT && op_q == OP_RST) |-> mosi);

  p_timeout_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && wcnt == WW'(READY_TIMEOUT - 1) && m2) |=> (rsp_done && rsp_err && cs_n));

  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

  p_no_ack_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && $past(state) != S_IDLE) |-> !req_ack);

  p_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
endmodule

// File: tb/tb_sdadc_reg_engine.sv
module tb_sdadc_reg_engine;
  localparam int RW = 20;
  localparam int TMO = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_hold = 1'b0, req_cread = 1'b0;
  logic [1:0] req_op = '0, req_len = '0;
  logic [2:0] req_addr = '0;
  logic [23:0] req_wdata = '0;
  logic [3:0] id_expect = 4'h6;
  logic req_ack, rsp_done, rsp_err, id_warn, sclk, cs_n, mosi, miso;
  logic [23:0] rsp_rdata;

  sdadc_reg_engine #(.CLK_DIV(2), .RESET_WAIT(RW), .READY_TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ack(req_ack),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .req_hold(req_hold), .req_cread(req_cread), .id_expect(id_expect),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .id_warn(id_warn),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  logic [63:0] cap = '0;
  int rise_cnt = 0, fall_cnt = 0, rise_base = 0, fall_base = 0;
  logic [47:0] slv = '0;
  bit use_rdy = 1'b0, rdy_lvl = 1'b1;

  always @(posedge sclk) if (!cs_n) begin cap <= {cap[62:0], mosi}; rise_cnt <= rise_cnt + 1; end
  always @(negedge sclk) if (!cs_n) fall_cnt <= fall_cnt + 1;

  always_comb begin
    int k;
    k = fall_cnt - fall_base;
    if (use_rdy) miso = rdy_lvl;
    else if (k >= 1 && k <= 48) miso = slv[48-k];
    else miso = 1'b1;
  end

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  bit g_err; logic [23:0] g_rd; int g_rise, g_hi; bit g_seen;

  task automatic run(input logic [1:0] op, input logic [2:0] a, input logic [1:0] l,
                     input logic [23:0] wd, input bit h, input logic [23:0] sd);
    logic [23:0] al;
    al = sd << (8 * (3 - int'(l)));
    @(negedge clk);
    slv = {8'h00, al, 16'h0};
    rise_base = rise_cnt; fall_base = fall_cnt;
    req_op = op; req_addr = a; req_len = l; req_wdata = wd; req_hold = h; req_valid = 1'b1;
    g_hi = 0; g_seen = 1'b0;
    for (int i = 0; i < 5000 && !g_seen; i++) begin
      @(negedge clk);
      if (req_ack) req_valid = 1'b0;
      if (cs_n) g_hi++;
      if (rsp_done) g_seen = 1'b1;
    end
    req_valid = 1'b0;
    g_err = rsp_err; g_rd = rsp_rdata; g_rise = rise_cnt - rise_base;
    check(g_seen, "R9 completion", 64'(g_seen), 64'd1);
  endtask

  function automatic logic [63:0] frame(input logic [1:0] op, input logic [2:0] a, input logic [1:0] l,
                                        input logic [23:0] wd, input bit cr);
    logic [7:0] c;
    logic [63:0] d;
    c = {1'b0, op == 2'd0, a, cr, 2'b00};
    d = (op == 2'd1) ? (64'(wd) & ((64'd1 << (8 * int'(l))) - 1)) : 64'd0;
    return (64'(c) << (8 * int'(l))) | d;
  endfunction

  localparam logic [54:0] TBL [6] = '{
    {2'd1, 3'd1, 2'd3, 24'h080060, 24'h000000},
    {2'd1, 3'd2, 2'd2, 24'h00A5C3, 24'h000000},
    {2'd1, 3'd5, 2'd1, 24'h000040, 24'h000000},
    {2'd0, 3'd3, 2'd3, 24'h000000, 24'h123456},
    {2'd0, 3'd1, 2'd2, 24'h000000, 24'h00BEEF},
    {2'd0, 3'd0, 2'd1, 24'h000000, 24'h000080}
  };

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    int nack, ndone, lat, nb;
    logic [63:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n && sclk && mosi, "R2 reset idle lines", {cs_n, sclk, mosi}, 3'b111);
    check(!req_ack && !rsp_done && !id_warn, "R9 reset outputs", {req_ack, rsp_done, id_warn}, 0);

    // R1 R2 R4 R6: table of accesses
    for (int i = 0; i < 6; i++) begin
      logic [1:0] op; logic [2:0] a; logic [1:0] l; logic [23:0] wd, sd;
      {op, a, l, wd, sd} = TBL[i];
      run(op, a, l, wd, 1'b0, sd);
      nb = 8 * (int'(l) + 1);
      m = (64'd1 << nb) - 1;
      check(g_rise == nb, "R2 edge count", 64'(g_rise), 64'(nb));
      check((cap & m) == frame(op, a, l, wd, 1'b0), "R1 frame bits", cap & m, frame(op, a, l, wd, 1'b0));
      check(!g_err && cs_n, "R6 release, no error", {g_err, cs_n}, 2'b01);
      if (op == 2'd0) check(g_rd == sd, "R4 right-aligned read", 64'(g_rd), 64'(sd));
    end

    // R1 continuous-read bit
    req_cread = 1'b1;
    run(2'd0, 3'd3, 2'd3, 24'h0, 1'b0, 24'h0F0F0F);
    check((cap & 64'hFFFF_FFFF) == frame(2'd0, 3'd3, 2'd3, 0, 1'b1), "R1 cread bit",
          cap & 64'hFFFF_FFFF, frame(2'd0, 3'd3, 2'd3, 0, 1'b1));
    req_cread = 1'b0;

    // R3 zero length
    run(2'd1, 3'd2, 2'd0, 24'hFFFFFF, 1'b0, 0);
    check(g_err && g_rise == 0 && cs_n, "R3 bad write length", {g_err, 8'(g_rise), cs_n}, {1'b1, 8'd0, 1'b1});
    run(2'd0, 3'd1, 2'd0, 24'h0, 1'b1, 0);
    check(g_err && g_rise == 0 && cs_n, "R3 bad read length", {g_err, 8'(g_rise), cs_n}, {1'b1, 8'd0, 1'b1});

    // R5 interface reset
    run(2'd2, 3'd0, 2'd0, 0, 1'b0, 0);
    check(g_rise == 48, "R5 48 clocks", 64'(g_rise), 64'd48);
    check(cap[47:0] == 48'hFFFF_FFFF_FFFF, "R5 all ones", 64'(cap[47:0]), 64'hFFFF_FFFF_FFFF);
    check(g_hi >= RW && !g_err, "R5 wait after pattern", 64'(g_hi), 64'(RW));

    // R6 R7: write with hold, wait ready, read data
    run(2'd1, 3'd1, 2'd3, 24'h200060, 1'b1, 0);
    check(!cs_n, "R6 chip select held", 64'(cs_n), 64'd0);
    use_rdy = 1'b1; rdy_lvl = 1'b1;
    @(negedge clk);
    req_op = 2'd3; req_hold = 1'b1; req_valid = 1'b1;
    nack = 0; ndone = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (req_ack) begin req_valid = 1'b0; nack++; end
      if (rsp_done) ndone++;
    end
    check(nack == 1 && ndone == 0, "R7 no early ready", {8'(nack), 8'(ndone)}, {8'd1, 8'd0});
    rdy_lvl = 1'b0;
    lat = 0;
    while (!rsp_done && lat < 20) begin @(negedge clk); lat++; end
    check(rsp_done && !rsp_err && !cs_n, "R7 ready seen", {rsp_done, rsp_err, cs_n}, 3'b100);
    use_rdy = 1'b0; rdy_lvl = 1'b1;
    run(2'd0, 3'd3, 2'd3, 0, 1'b0, 24'hA1B2C3);
    check(g_rd == 24'hA1B2C3 && cs_n, "R4 data after ready", 64'(g_rd), 64'hA1B2C3);

    // R7 timeout
    use_rdy = 1'b1; rdy_lvl = 1'b1;
    run(2'd3, 3'd0, 2'd0, 0, 1'b1, 0);
    check(g_err && cs_n, "R7 timeout releases", {g_err, cs_n}, 2'b11);
    use_rdy = 1'b0;

    // R8 identity
    id_expect = 4'h6;
    run(2'd0, 3'd4, 2'd1, 0, 1'b0, 24'h46);
    check(!id_warn && !g_err, "R8 id match", {id_warn, g_err}, 2'b00);
    run(2'd0, 3'd4, 2'd1, 0, 1'b0, 24'h44);
    check(id_warn && !g_err && g_rd == 24'h44, "R8 id mismatch", {id_warn, g_err}, 2'b10);
    run(2'd0, 3'd4, 2'd1, 0, 1'b0, 24'h16);
    check(!id_warn, "R8 upper nibble ignored", 64'(id_warn), 64'd0);

    // R9 request held during busy transfer
    @(negedge clk);
    req_op = 2'd1; req_addr = 3'd6; req_len = 2'd3; req_wdata = 24'h123456; req_hold = 1'b0;
    req_valid = 1'b1;
    while (!req_ack) @(negedge clk);
    nack = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (req_ack) nack++; end
    req_valid = 1'b0;
    check(nack == 0, "R9 no ack while busy", 64'(nack), 64'd0);
    lat = 0;
    while (!rsp_done && lat < 500) begin @(negedge clk); lat++; end
    check(rsp_done && !rsp_err, "R9 held request completes", {rsp_done, rsp_err}, 2'b10);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule